// File: doc/BRIEF.md
# Access-Filtered System Descriptor Register Bank

This block is a small bank of 32-bit registers on a simple valid/ready bus. It describes the processor and its memories to software. One word packs the size codes and way counts of the instruction and data caches. A second word holds a fixed core information value. An indexed array of memory descriptor entries follows. Each entry joins fixed information with a few control bits that software can write. All fixed values come from parameters at elaboration. The cache size codes are derived from capacities given in bytes.

Every request carries a master ID, a privilege flag and a transfer size, and the block filters each request on these attributes. A user-mode request, a request that is not a word, or a misaligned request ends in a bus error. A request to an unmapped offset also ends in a bus error. A privileged word request from a master outside the core/debug set completes without error: a read returns zeros and a write is dropped. Requests from core or debug masters are served normally. A write changes only the bits that are marked writable.

Top module: `sysdesc_regs`

## Requirements
- R1: A privileged word read from a core/debug master returns the register contents with no error. Core/debug masters are the IDs whose bit is set in CPU_MASK (default: IDs 0, 1 and 7). The map is: offset 0x00 is the cache word, 0x04 is the core info word, and 0x10 + 4*i is memory entry i.
- R2: The cache word holds the instruction cache size code in [31:24], the instruction cache way count in [23:16], the data cache size code in [15:8] and the data cache way count in [7:0]. For a capacity of 2^(8+c) bytes the code is c. A capacity of zero gives code 0, which means the cache is absent. With the defaults the word is 0x05020000.
- R3: A privileged word read from any other master completes with no error and returns all zeros.
- R4: A privileged word write from any other master completes with no error and leaves every register unchanged.
- R5: Any user-mode request (priv = 0) gets a bus error with zero read data and changes no register.
- R6: A request whose size code is not word gets a bus error and changes no register. The size codes are 0 byte, 1 half, 2 word and 3 reserved.
- R7: A core/debug write to a memory entry updates only the bits set in that entry's writable mask. All other bits keep their fixed values.
- R8: A core/debug write to the cache word or the core info word completes with no error and changes nothing.
- R9: A request to an unmapped word offset, or with address bits [1:0] non-zero, gets a bus error.
- R10: Reset clears all writable bits and holds rsp_valid_o low. req_ready_o goes high on the first clock after reset is released.
- R11: Each accepted request produces exactly one response, on the following cycle. No response appears in a cycle that follows no accepted request.
- R12: The fault checks take priority over master filtering. A user-mode or non-word request from a non-core master gets a bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | ADDR_W | Byte offset within the block |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Transfer size code |
| req_priv_i | input | 1 | 1 = privileged request |
| req_master_i | input | MID_W | Requesting master ID |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata_o | output | 32 | Read data; zero for writes and errors |
| rsp_err_o | output | 1 | Bus error |

## Verification
The bench checks that writes honour each entry's writable mask. A design that ignored the mask would corrupt the fixed fields, and one that dropped the write would leave the control bits at zero. After each rejected request (user mode, wrong size, or a foreign master), the bench reads the target back through a legal request. This exposes a filter that answers correctly but still writes the register. Non-core masters are also sent faulting requests, which catches a design that checks the master before privilege and size and so returns zeros where an error is due. Misaligned, gap and past-the-end offsets are probed, and an entry is read again after a mid-run reset to confirm that its control bits were cleared.

// File: rtl/sysdesc_pkg.sv
package sysdesc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ACT_NORMAL = 2'd0,
    ACT_ZERO   = 2'd1,
    ACT_FAULT  = 2'd2
  } access_act_e;

  // capacity of 2^(8+c) bytes -> c; zero capacity -> 0 (absent)
  function automatic logic [7:0] size_code(input longint unsigned bytes);
    logic [7:0] code;
    code = 8'd0;
    if (bytes != 0) begin
      for (int k = 8; k < 40; k++) begin
        if ((longint'(1) << k) == bytes) code = 8'(k - 8);
      end
    end
    return code;
  endfunction

endpackage

// File: rtl/sysdesc_policy.sv
module sysdesc_policy
  import sysdesc_pkg::*;
#(
  parameter int          MID_W    = 3,
  parameter logic [(1<<MID_W)-1:0] CPU_MASK = '1
) (
  input  logic             priv_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       addr_lo_i,
  input  logic [MID_W-1:0] master_i,
  input  logic             hit_i,
  output access_act_e      act_o
);

  logic fault;
  logic trusted;

  assign trusted = CPU_MASK[master_i];
  // faults first: user mode, size, alignment, then map holes
  assign fault = !priv_i || (size_i != SZ_WORD) || (addr_lo_i != 2'b00) || !hit_i;

  always_comb begin
    if (fault)         act_o = ACT_FAULT;
    else if (!trusted) act_o = ACT_ZERO;
    else               act_o = ACT_NORMAL;
  end

endmodule

// File: rtl/sysdesc_decode.sv
module sysdesc_decode #(
  parameter int ADDR_W   = 6,
  parameter int NUM_MEM  = 4,
  parameter int MEM_BASE = 16
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               sel_cfg_o,
  output logic               sel_core_o,
  output logic [NUM_MEM-1:0] sel_mem_o,
  output logic               hit_o
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int BASE_IDX = MEM_BASE / 4;

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[ADDR_W-1:2];

  assign sel_cfg_o  = (idx == IDX_W'(0));
  assign sel_core_o = (idx == IDX_W'(1));

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_sel
    assign sel_mem_o[g] = (idx == IDX_W'(BASE_IDX + g));
  end

  assign hit_o = sel_cfg_o || sel_core_o || (|sel_mem_o);

endmodule

// File: rtl/sysdesc_entry.sv
module sysdesc_entry #(
  parameter logic [31:0] INFO  = '0,
  parameter logic [31:0] WMASK = '0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] value_o
);

  logic [31:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i & WMASK;
  end

  assign value_o = (INFO & ~WMASK) | ctrl_q;

endmodule

// File: rtl/sysdesc_regs.sv
module sysdesc_regs
  import sysdesc_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          MID_W     = 3,
  parameter logic [(1<<MID_W)-1:0] CPU_MASK = 8'h83,
  parameter longint unsigned IC_BYTES = 8192,
  parameter int          IC_WAYS   = 2,
  parameter longint unsigned DC_BYTES = 0,
  parameter int          DC_WAYS   = 0,
  parameter logic [31:0] CORE_INFO = 32'h0000_0C01,
  parameter int          NUM_MEM   = 4,
  parameter int          MEM_BASE  = 16,
  parameter logic [NUM_MEM*32-1:0] MEM_INFO =
    {32'h0000_0000, 32'h0B03_0000, 32'h0C02_0000, 32'h0D01_0000},
  parameter logic [NUM_MEM*32-1:0] MEM_WMASK =
    {32'h0000_0000, 32'h0000_0000, 32'h0000_000F, 32'h0000_00FF}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_priv_i,
  input  logic [MID_W-1:0]  req_master_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              rsp_err_o
);

  localparam logic [31:0] CFG_WORD = {size_code(IC_BYTES), 8'(IC_WAYS),
                                      size_code(DC_BYTES), 8'(DC_WAYS)};

  logic               ready_q;
  logic               acc;
  logic               sel_cfg, sel_core, hit;
  logic [NUM_MEM-1:0] sel_mem;
  access_act_e        act;
  logic               wr_en;
  logic [31:0]        ent_val [NUM_MEM];
  logic [31:0]        mem_rd;
  logic [31:0]        rd_word;

  logic               rsp_valid_q, rsp_err_q;
  logic [31:0]        rsp_rdata_q;

  sysdesc_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_MEM (NUM_MEM),
    .MEM_BASE(MEM_BASE)
  ) u_dec (
    .addr_i    (req_addr_i),
    .sel_cfg_o (sel_cfg),
    .sel_core_o(sel_core),
    .sel_mem_o (sel_mem),
    .hit_o     (hit)
  );

  sysdesc_policy #(
    .MID_W   (MID_W),
    .CPU_MASK(CPU_MASK)
  ) u_pol (
    .priv_i   (req_priv_i),
    .size_i   (req_size_i),
    .addr_lo_i(req_addr_i[1:0]),
    .master_i (req_master_i),
    .hit_i    (hit),
    .act_o    (act)
  );

  assign acc   = req_valid_i && ready_q;
  assign wr_en = acc && req_we_i && (act == ACT_NORMAL);

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_ent
    sysdesc_entry #(
      .INFO (MEM_INFO[g*32 +: 32]),
      .WMASK(MEM_WMASK[g*32 +: 32])
    ) u_ent (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en && sel_mem[g]),
      .wdata_i(req_wdata_i),
      .value_o(ent_val[g])
    );
  end

  always_comb begin
    mem_rd = '0;
    for (int i = 0; i < NUM_MEM; i++) begin
      if (sel_mem[i]) mem_rd = mem_rd | ent_val[i];
    end
  end

  always_comb begin
    if (sel_cfg)       rd_word = CFG_WORD;
    else if (sel_core) rd_word = CORE_INFO;
    else               rd_word = mem_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= acc;
      rsp_err_q   <= acc && (act == ACT_FAULT);
      rsp_rdata_q <= (acc && !req_we_i && act == ACT_NORMAL) ? rd_word : '0;
    end
  end

  assign req_ready_o = ready_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_err_o   = rsp_err_q;

endmodule

// File: rtl/sysdesc_regs_chk.sv
module sysdesc_regs_chk #(
  parameter int MID_W = 3,
  parameter logic [(1<<MID_W)-1:0] CPU_MASK = '1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_we_i,
  input logic [1:0]       req_size_i,
  input logic             req_priv_i,
  input logic [MID_W-1:0] req_master_i,
  input logic             rsp_valid_o,
  input logic [31:0]      rsp_rdata_o,
  input logic             rsp_err_o
);

  logic acc;
  assign acc = req_valid_i && req_ready_o;

  a_r11_rsp_follows_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);

  a_r11_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rsp_valid_o);

  a_r5_user_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_priv_i) |=> (rsp_err_o && rsp_rdata_o == 32'h0));

  a_r6_size_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_size_i != 2'd2) |=> rsp_err_o);

  a_r3_foreign_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_we_i && !CPU_MASK[req_master_i]) |=> (rsp_rdata_o == 32'h0));

  a_r12_err_only_with_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_valid_o);

endmodule

bind sysdesc_regs sysdesc_regs_chk #(
  .MID_W   (MID_W),
  .CPU_MASK(CPU_MASK)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_we_i    (req_we_i),
  .req_size_i  (req_size_i),
  .req_priv_i  (req_priv_i),
  .req_master_i(req_master_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_err_o   (rsp_err_o)
);

// File: tb/sim_sysdesc_regs.sv
module sim_sysdesc_regs;

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic        priv;
    logic [2:0]  mid;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic        exp_err;
    logic [31:0] exp_rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h00, 32'h0,         1'b0, 32'h0502_0000, 4'd2},  // R2 cache word
    '{1'b0, 2'd2, 1'b1, 3'd7, 6'h04, 32'h0,         1'b0, 32'h0000_0C01, 4'd1},  // R1 debug master
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h10, 32'h0,         1'b0, 32'h0D01_0000, 4'd1},  // R1 entry0
    '{1'b1, 2'd2, 1'b1, 3'd0, 6'h10, 32'hFFFF_FFA5, 1'b0, 32'h0,         4'd7},  // R7 masked write
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h10, 32'h0,         1'b0, 32'h0D01_00A5, 4'd7},
    '{1'b1, 2'd2, 1'b1, 3'd1, 6'h14, 32'hFFFF_FFFF, 1'b0, 32'h0,         4'd7},
    '{1'b0, 2'd2, 1'b1, 3'd1, 6'h14, 32'h0,         1'b0, 32'h0C02_000F, 4'd7},
    '{1'b0, 2'd2, 1'b1, 3'd3, 6'h14, 32'h0,         1'b0, 32'h0,         4'd3},  // R3 foreign read
    '{1'b0, 2'd2, 1'b1, 3'd5, 6'h00, 32'h0,         1'b0, 32'h0,         4'd3},
    '{1'b1, 2'd2, 1'b1, 3'd3, 6'h10, 32'h0,         1'b0, 32'h0,         4'd4},  // R4 foreign write
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h10, 32'h0,         1'b0, 32'h0D01_00A5, 4'd4},
    '{1'b1, 2'd2, 1'b0, 3'd0, 6'h10, 32'h0,         1'b1, 32'h0,         4'd5},  // R5 user write
    '{1'b0, 2'd2, 1'b0, 3'd0, 6'h10, 32'h0,         1'b1, 32'h0,         4'd5},  // R5 user read
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h10, 32'h0,         1'b0, 32'h0D01_00A5, 4'd5},
    '{1'b1, 2'd0, 1'b1, 3'd0, 6'h10, 32'h0,         1'b1, 32'h0,         4'd6},  // R6 byte
    '{1'b0, 2'd1, 1'b1, 3'd0, 6'h10, 32'h0,         1'b1, 32'h0,         4'd6},  // R6 half
    '{1'b1, 2'd3, 1'b1, 3'd7, 6'h10, 32'h0,         1'b1, 32'h0,         4'd6},  // R6 reserved
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h10, 32'h0,         1'b0, 32'h0D01_00A5, 4'd6},
    '{1'b1, 2'd2, 1'b1, 3'd0, 6'h00, 32'h0,         1'b0, 32'h0,         4'd8},  // R8 read-only word
    '{1'b1, 2'd2, 1'b1, 3'd7, 6'h04, 32'hFFFF_FFFF, 1'b0, 32'h0,         4'd8},
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h00, 32'h0,         1'b0, 32'h0502_0000, 4'd8},
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h04, 32'h0,         1'b0, 32'h0000_0C01, 4'd8},
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h08, 32'h0,         1'b1, 32'h0,         4'd9},  // R9 gap
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h20, 32'h0,         1'b1, 32'h0,         4'd9},  // R9 past end
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h11, 32'h0,         1'b1, 32'h0,         4'd9},  // R9 misaligned
    '{1'b0, 2'd2, 1'b0, 3'd3, 6'h10, 32'h0,         1'b1, 32'h0,         4'd12}, // R12 foreign user
    '{1'b1, 2'd0, 1'b1, 3'd3, 6'h10, 32'h0,         1'b1, 32'h0,         4'd12}, // R12 foreign byte
    '{1'b1, 2'd2, 1'b1, 3'd0, 6'h18, 32'hFFFF_FFFF, 1'b0, 32'h0,         4'd7},
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h18, 32'h0,         1'b0, 32'h0B03_0000, 4'd7},
    '{1'b0, 2'd2, 1'b1, 3'd0, 6'h1C, 32'h0,         1'b0, 32'h0,         4'd1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [5:0]  req_addr_i = '0;
  logic        req_we_i = 1'b0;
  logic [1:0]  req_size_i = 2'd2;
  logic        req_priv_i = 1'b1;
  logic [2:0]  req_master_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        rsp_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  sysdesc_regs u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_we_i    (req_we_i),
    .req_size_i  (req_size_i),
    .req_priv_i  (req_priv_i),
    .req_master_i(req_master_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_err_o   (rsp_err_o)
  );

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got valid/err/data %h, expected %h", tag, act, exp);
    end
  endtask

  // drive one request at a falling edge, sample its response one cycle later
  task automatic apply(input vec_t v);
    req_valid_i  = 1'b1;
    req_we_i     = v.we;
    req_size_i   = v.sz;
    req_priv_i   = v.priv;
    req_master_i = v.mid;
    req_addr_i   = v.addr;
    req_wdata_i  = v.wdata;
    @(negedge clk_i);
    check($sformatf("R%0d", v.req), {rsp_valid_o, rsp_err_o, rsp_rdata_o},
          {1'b1, v.exp_err, v.exp_rd});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset rsp", {rsp_valid_o, req_ready_o, 32'h0}, {1'b0, 1'b0, 32'h0});
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 ready", {rsp_valid_o, req_ready_o, 32'h0}, {1'b0, 1'b1, 32'h0});

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R11 idle", {rsp_valid_o, rsp_err_o, rsp_rdata_o}, {1'b0, 1'b0, 32'h0});

    // mid-run reset clears entry0 control bits
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R10 rsp in reset", {rsp_valid_o, 33'h0}, 34'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    apply('{1'b0, 2'd2, 1'b1, 3'd0, 6'h10, 32'h0, 1'b0, 32'h0D01_0000, 4'd10});  // R10
    apply('{1'b0, 2'd2, 1'b1, 3'd1, 6'h14, 32'h0, 1'b0, 32'h0C02_0000, 4'd10});  // R10
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R11 idle after", {rsp_valid_o, 33'h0}, 34'h0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule